// File: doc/BRIEF.md
# SEC-DED ECC Checker and Error Log

This block protects a 32-bit memory word with 7 check bits. On the write side, a combinational encoder turns the write data into check bits. It can also poison them on request, so that a word written after a bus parity fault reads back as uncorrectable.

On the read side, the block recomputes the check bits from the returned data and XORs them with the stored check bits to form a syndrome. It then classifies the read in the same cycle:
- A flipped data bit is corrected.
- A flipped check bit is reported without touching the data.
- Any other non-zero syndrome is reported as uncorrectable.

The code is affine rather than linear. All-zero data carries a fixed non-zero check value, and inverting every data bit leaves the check bits unchanged.

Each qualified read that finds an error is recorded in a single 32-bit status register. The register holds sticky class flags, the 512-byte page number of the failing access, a DMA marker, a bus parity marker and the last captured syndrome. Software clears the flags by writing ones to them. The page and syndrome fields cannot be written.

Top module: `secded_log`

## Requirements
- R1: Check bits equal 0111100 XOR the columns of every set data bit. Zero data gives 0111100. Data 0x00000001 gives 1100100, 0x80000000 gives 1000101 and 0x10000000 gives 1000011. Data 0x80800201 gives 0000000 and 0x90800201 gives 1111111.
- R2: Inverting all 32 data bits leaves the generated check bits unchanged.
- R3: With `wr_poison` high, the generated check bits are XORed with 0000111.
- R4: The syndrome is the recomputed check bits XOR `rd_check`. A zero syndrome returns the data unchanged with both class outputs low, and nothing is logged.
- R5: A syndrome equal to one data column flips that bit in `rd_fixed` in the same cycle and raises `rd_corr`. For example, bit 0 has column 1011000 and bit 31 has column 1111001.
- R6: A syndrome with exactly one bit set is a check-bit error. Data passes unchanged and `rd_corr` is raised.
- R7: Any other non-zero syndrome, including 0000111 and two flipped data bits, raises `rd_uncorr` and returns the data unmodified.
- R8: Status layout, from the top bit down:
  - bit 31: uncorrectable
  - bit 30: multiple uncorrectable
  - bit 29: correctable
  - bits 28:9: page
  - bit 8: DMA
  - bit 7: bus parity
  - bits 6:0: syndrome

  A logged uncorrectable read sets bit 31 and captures the page and syndrome at the next clock edge.
- R9: An uncorrectable read while bit 31 is already set also sets bit 30.
- R10: A correctable read sets bit 29. It captures page and syndrome only while bit 31 is clear.
- R11: Bit 8 sets when a logged read (correctable or uncorrectable) has `rd_dma` high.
- R12: A pulse on `bus_par_err` sets bit 7.
- R13: Writing 1 clears bits 31, 30, 29, 8 and 7. Writes never change bits 28:9 or 6:0. A new event in the same cycle as a clear wins.
- R14: After reset the status register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 32 | Data word to encode |
| wr_poison | input | 1 | Force poisoned check bits |
| wr_check | output | 7 | Generated check bits |
| rd_valid | input | 1 | Qualifies the read for logging |
| rd_data | input | 32 | Data word read from memory |
| rd_check | input | 7 | Check bits read from memory |
| rd_addr | input | 20 | Address bits 28:9 of the access (page number) |
| rd_dma | input | 1 | Access was made by DMA |
| rd_fixed | output | 32 | Corrected read data |
| rd_corr | output | 1 | Correctable error on this read |
| rd_uncorr | output | 1 | Uncorrectable error on this read |
| bus_par_err | input | 1 | Bus parity fault pulse |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 32 | Write-one-to-clear data |
| csr_rdata | output | 32 | Status register contents |

## Verification
The encoder is tried with zero data, single-bit words, known combinations that give all-zero and all-one check bits, and a word and its complement. Together these tell the affine constant apart from the per-bit columns.

The read path is tried in four ways:
- a clean word;
- every one of the 32 single data-bit flips on one base word, which separates correction from mere detection;
- every single check-bit flip, which must leave the data alone;
- a double data flip and a poisoned word, which must both be uncorrectable.

Log sequences then distinguish first capture, the multiple-error flag, the hold of fields under a correctable error, partial clears with ones written to read-only fields, and a clear that collides with a new event.

// File: rtl/secded_log.sv
`timescale 1ns/1ps
module secded_log #(
  parameter int PG_LSB = 9,
  parameter int PG_W   = 20,
  parameter int SW     = PG_W + 12,
  localparam int DW    = 32,
  localparam int CW    = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DW-1:0]              wr_data,
  input  logic                       wr_poison,
  output logic [CW-1:0]              wr_check,
  input  logic                       rd_valid,
  input  logic [DW-1:0]              rd_data,
  input  logic [CW-1:0]              rd_check,
  input  logic [PG_LSB+PG_W-1:PG_LSB] rd_addr,
  input  logic                       rd_dma,
  output logic [DW-1:0]              rd_fixed,
  output logic                       rd_corr,
  output logic                       rd_uncorr,
  input  logic                       bus_par_err,
  input  logic                       csr_wr,
  input  logic [SW-1:0]              csr_wdata,
  output logic [SW-1:0]              csr_rdata
);

  localparam logic [CW-1:0] CK_BASE = 7'b0111100;
  localparam logic [CW-1:0] POISON  = 7'b0000111;
  localparam int B_UNC = SW - 1;
  localparam int B_MUL = SW - 2;
  localparam int B_COR = SW - 3;
  localparam int B_DMA = PG_LSB - 1;
  localparam int B_PAR = PG_LSB - 2;

  localparam logic [CW-1:0] COL [DW] = '{
    7'b1011000, 7'b0011100, 7'b0011010, 7'b1011110,
    7'b0011111, 7'b1011011, 7'b1011101, 7'b0011001,
    7'b1101000, 7'b0101100, 7'b0101010, 7'b1101110,
    7'b0101111, 7'b1101011, 7'b1101101, 7'b0101001,
    7'b1110000, 7'b0110100, 7'b0110010, 7'b1110110,
    7'b0110111, 7'b1110011, 7'b1110101, 7'b0110001,
    7'b0111000, 7'b1111100, 7'b1111010, 7'b0111110,
    7'b1111111, 7'b0111011, 7'b0111101, 7'b1111001
  };

  function automatic logic [CW-1:0] gen_chk(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = CK_BASE;
    for (int i = 0; i < DW; i++)
      if (d[i]) c = c ^ COL[i];
    return c;
  endfunction

  assign wr_check = gen_chk(wr_data) ^ (wr_poison ? POISON : '0);

  logic [CW-1:0] syn;
  logic [DW-1:0] fix;
  logic          hit;
  logic          chk_bit_err;

  assign syn = gen_chk(rd_data) ^ rd_check;

  always_comb begin
    fix = '0;
    hit = 1'b0;
    for (int i = 0; i < DW; i++)
      if (syn == COL[i]) begin
        fix[i] = 1'b1;
        hit    = 1'b1;
      end
  end

  assign chk_bit_err = $onehot(syn);
  assign rd_corr     = hit | chk_bit_err;
  assign rd_uncorr   = (syn != '0) & ~rd_corr;
  assign rd_fixed    = rd_data ^ fix;

  logic            f_unc, f_mul, f_cor, f_dma, f_par;
  logic [PG_W-1:0] pg_r;
  logic [CW-1:0]   syn_r;
  logic            log_unc, log_cor;
  logic            clr_unc, clr_mul, clr_cor, clr_dma, clr_par;
  logic            unused_wbits;

  assign log_unc = rd_valid & rd_uncorr;
  assign log_cor = rd_valid & rd_corr;
  assign clr_unc = csr_wr & csr_wdata[B_UNC];
  assign clr_mul = csr_wr & csr_wdata[B_MUL];
  assign clr_cor = csr_wr & csr_wdata[B_COR];
  assign clr_dma = csr_wr & csr_wdata[B_DMA];
  assign clr_par = csr_wr & csr_wdata[B_PAR];
  assign unused_wbits = ^{csr_wdata[B_COR-1:PG_LSB], csr_wdata[B_PAR-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_unc <= 1'b0;
      f_mul <= 1'b0;
      f_cor <= 1'b0;
      f_dma <= 1'b0;
      f_par <= 1'b0;
      pg_r  <= '0;
      syn_r <= '0;
    end else begin
      f_unc <= (f_unc & ~clr_unc) | log_unc;
      f_mul <= (f_mul & ~clr_mul) | (log_unc & f_unc);
      f_cor <= (f_cor & ~clr_cor) | log_cor;
      f_dma <= (f_dma & ~clr_dma) | ((log_unc | log_cor) & rd_dma);
      f_par <= (f_par & ~clr_par) | bus_par_err;
      if (log_unc | (log_cor & ~f_unc)) begin
        pg_r  <= rd_addr;
        syn_r <= syn;
      end
    end
  end

  assign csr_rdata = {f_unc, f_mul, f_cor, pg_r, f_dma, f_par, syn_r};

  AST_UNC_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_uncorr |-> rd_fixed == rd_data);  // R7
  AST_UNC_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    log_unc |=> csr_rdata[B_UNC] && syn_r == $past(syn));  // R8
  AST_MULTI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    log_unc && csr_rdata[B_UNC] |=> csr_rdata[B_MUL]);  // R9
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    log_cor && csr_rdata[B_UNC] |=> $stable(pg_r) && $stable(syn_r));  // R10
  AST_PAR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_par_err |=> csr_rdata[B_PAR]);  // R12
  AST_UNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[B_UNC] && !clr_unc |=> csr_rdata[B_UNC]);  // R13
  AST_RO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(pg_r) && $stable(syn_r));  // R13

endmodule

// File: tb/secded_log_test.sv
`timescale 1ns/1ps
module secded_log_test;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_poison = 1'b0;
  logic [6:0]  wr_check;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic [6:0]  rd_check = '0;
  logic [28:9] rd_addr = '0;
  logic        rd_dma = 1'b0;
  logic [31:0] rd_fixed;
  logic        rd_corr, rd_uncorr;
  logic        bus_par_err = 1'b0;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;

  always #(PER/2) clk = ~clk;

  secded_log uut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_poison(wr_poison),
    .wr_check(wr_check), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_check(rd_check), .rd_addr(rd_addr), .rd_dma(rd_dma),
    .rd_fixed(rd_fixed), .rd_corr(rd_corr), .rd_uncorr(rd_uncorr),
    .bus_par_err(bus_par_err), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata)
  );

  typedef struct {
    int          kind;
    logic [31:0] d;
    logic        c;
    logic        u;
    logic [6:0]  k;
    string       tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [19:0] PG1 = 20'h12345;
  localparam logic [19:0] PG2 = 20'h0BEEF;
  localparam logic [19:0] PG3 = 20'h00A5A;
  localparam logic [19:0] PG4 = 20'hFFFFF;
  localparam logic [31:0] BASE = 32'hA5C30F96;

  function automatic logic [31:0] st(bit u, bit m, bit c, logic [19:0] pg,
                                     bit dma, bit par, logic [6:0] s);
    return {u, m, c, pg, dma, par, s};
  endfunction

  task automatic idle_in();
    wr_poison = 1'b0; rd_valid = 1'b0; rd_dma = 1'b0;
    bus_par_err = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic enc_chk(input logic [31:0] d, input logic pz,
                         input logic [6:0] exp, input string tag);
    item_t it;
    @(negedge clk); idle_in();
    wr_data = d; wr_poison = pz;
    it.kind = 2; it.k = exp; it.d = '0; it.c = 1'b0; it.u = 1'b0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic enc_get(input logic [31:0] d, output logic [6:0] k);
    @(negedge clk); idle_in();
    wr_data = d;
    #1 k = wr_check;
  endtask

  task automatic rd(input logic [31:0] d, input logic [6:0] k,
                    input logic [19:0] pg, input logic dma,
                    input logic [31:0] exp_d, input logic c, input logic u,
                    input string tag);
    item_t it;
    @(negedge clk); idle_in();
    rd_valid = 1'b1; rd_data = d; rd_check = k; rd_addr = pg; rd_dma = dma;
    it.kind = 0; it.d = exp_d; it.c = c; it.u = u; it.k = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic csr_check(input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk); idle_in();
    it.kind = 1; it.d = exp; it.c = 1'b0; it.u = 1'b0; it.k = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic csr_write(input logic [31:0] w);
    @(negedge clk); idle_in();
    csr_wr = 1'b1; csr_wdata = w;
  endtask

  initial forever begin
    @(negedge clk);
    #(PER/4);
    if (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      case (cur.kind)
        0: if (rd_fixed !== cur.d || rd_corr !== cur.c || rd_uncorr !== cur.u) begin
             errors++;
             $display("FAIL %s read: data=%h corr=%b uncorr=%b expected data=%h corr=%b uncorr=%b",
                      cur.tag, rd_fixed, rd_corr, rd_uncorr, cur.d, cur.c, cur.u);
           end
        1: if (csr_rdata !== cur.d) begin
             errors++;
             $display("FAIL %s status: got %h expected %h", cur.tag, csr_rdata, cur.d);
           end
        default: if (wr_check !== cur.k) begin
             errors++;
             $display("FAIL %s encode: got %b expected %b", cur.tag, wr_check, cur.k);
           end
      endcase
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] k;
    logic [6:0] k2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    csr_check(32'h0, "R14");

    // R1: affine constant and known columns
    enc_chk(32'h00000000, 1'b0, 7'b0111100, "R1");
    enc_chk(32'h00000001, 1'b0, 7'b1100100, "R1");
    enc_chk(32'h80000000, 1'b0, 7'b1000101, "R1");
    enc_chk(32'h10000000, 1'b0, 7'b1000011, "R1");
    enc_chk(32'h80800201, 1'b0, 7'b0000000, "R1");
    enc_chk(32'h90800201, 1'b0, 7'b1111111, "R1");

    // R2: complement invariance
    enc_chk(32'hFFFFFFFF, 1'b0, 7'b0111100, "R2");
    enc_chk(32'hFFFFFFFE, 1'b0, 7'b1100100, "R2");
    enc_get(32'h12345678, k);
    enc_chk(~32'h12345678, 1'b0, k, "R2");

    // R3: poison
    enc_chk(32'h00000000, 1'b1, 7'b0111011, "R3");
    enc_chk(32'h80800201, 1'b1, 7'b0000111, "R3");

    // R4: clean read, no logging
    rd(32'h80800201, 7'b0000000, PG1, 1'b0, 32'h80800201, 1'b0, 1'b0, "R4");
    csr_check(32'h0, "R4");

    // R5: every single data-bit flip is corrected
    enc_get(BASE, k);
    for (int i = 0; i < 32; i++)
      rd(BASE ^ (32'h1 << i), k, PG2, 1'b0, BASE, 1'b1, 1'b0, "R5");
    csr_check(st(0,0,1,PG2,0,0,7'b1111001), "R5");

    // R13: clear all flags, fields stay
    csr_write(32'hFFFFFFFF);
    csr_check(st(0,0,0,PG2,0,0,7'b1111001), "R13");

    // R6: check-bit flips, R11: DMA marker on the last one
    for (int j = 0; j < 7; j++)
      rd(BASE, k ^ (7'h1 << j), PG3, (j == 6), BASE, 1'b1, 1'b0, "R6");
    csr_check(st(0,0,1,PG3,1,0,7'b1000000), "R11");
    csr_write(32'hFFFFFFFF);
    csr_check(st(0,0,0,PG3,0,0,7'b1000000), "R13");

    // R7/R8: double data flip is uncorrectable and logged
    rd(32'h00000003, 7'b0111100, PG1, 1'b0, 32'h00000003, 1'b0, 1'b1, "R7");
    csr_check(st(1,0,0,PG1,0,0,7'b1000100), "R8");

    // R7/R9: poisoned word while uncorrectable already logged
    rd(32'h00000000, 7'b0111011, PG4, 1'b0, 32'h00000000, 1'b0, 1'b1, "R7");
    csr_check(st(1,1,0,PG4,0,0,7'b0000111), "R9");

    // R10: correctable error does not overwrite fields
    rd(32'h00000001, 7'b0111100, PG2, 1'b0, 32'h00000000, 1'b1, 1'b0, "R10");
    csr_check(st(1,1,1,PG4,0,0,7'b0000111), "R10");

    // R12: bus parity pulse
    @(negedge clk); idle_in(); bus_par_err = 1'b1;
    csr_check(st(1,1,1,PG4,0,1,7'b0000111), "R12");

    // R13: partial clear with ones on read-only fields
    csr_write({3'b001, 20'hFFFFF, 1'b0, 1'b1, 7'h7F});
    csr_check(st(1,1,0,PG4,0,0,7'b0000111), "R13");

    // R13: new uncorrectable event beats a same-cycle clear
    enc_get(32'h0, k2);
    @(negedge clk); idle_in();
    rd_valid = 1'b1; rd_data = 32'h00000003; rd_check = k2; rd_addr = PG1;
    csr_wr = 1'b1; csr_wdata = 32'hC0000000;
    begin
      item_t it;
      it.kind = 0; it.d = 32'h00000003; it.c = 1'b0; it.u = 1'b1; it.k = '0; it.tag = "R13";
      q.push_back(it);
    end
    csr_check(st(1,1,0,PG1,0,0,7'b1000100), "R13");

    csr_write(32'hFFFFFFFF);
    csr_check(st(0,0,0,PG1,0,0,7'b1000100), "R13");

    wait (q.size() == 0);
    @(negedge clk);
    #(PER/2);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule